// File: doc/BRIEF.md
# Masked Error Detection Interrupt Unit

This block watches a data-processing execution unit for a fixed set of fault conditions. It snoops the unit's register accesses and a handful of FIFO and sequencing event pins. It keeps a sticky error-status register and an error-mask register, both 32 bits wide and both reachable from software. An error that is enabled in the mask is recorded in the status register. The unit then raises its single error interrupt and tells the processing core to halt. An error whose mask bit is set is thrown away: no status bit, no interrupt, no halt.

Five conditions are detected:
- a write of an out-of-range value to the mode register;
- any read or write to an unused offset of the unit's register window;
- a write of the data-size register while the output FIFO still holds data;
- a done event while the input FIFO still holds data;
- a push into the input FIFO while it is full.

Software clears recorded errors by writing ones to the status register. The interrupt and the halt stay active until every recorded bit is gone.

No data stream passes through this block. The FIFO and done inputs are single-cycle observations of status sampled on the clock, and every pin is plain level or pulse control. There is no valid/ready handshake and no back-pressure. The register port is a simple single-cycle strobe interface. Read data is combinational from the offset presented while the read strobe is high.

Top module: `err_guard_unit`

## Requirements
- R1: After reset, the status and mask registers both read 0, the mode register reads 0, and `err_irq` and `core_halt` are 0.
- R2: The register offsets are: status at 0x00, mask at 0x04, mode at 0x08 and data size at 0x0C. The data-size register has no storage and reads 0. A write to 0x04 stores only the defined error bits: 31 (mode), 30 (address), 29 (output FIFO), 28 (input FIFO) and 26 (input overflow). All other mask bits read 0.
- R3: If the mask bit of a detected error is 1, the status register does not change for that error and no interrupt is raised.
- R4: If the mask bit of a detected error is 0, its status bit reads 1 from the cycle after the triggering clock edge, and `err_irq` and `core_halt` are 1 in that cycle. The mask value in force before the edge decides, even if the mask is written in the same cycle.
- R5: A write to 0x08 with a data value of 6 or more (NUM_MODES=6) sets status bit 31 and leaves the stored mode unchanged. A write of a legal value stores it, and it reads back at 0x08.
- R6: A read or write strobe with an offset outside {0x00, 0x04, 0x08, 0x0C} sets status bit 30. An access to one of those four offsets never does.
- R7: A write to 0x0C while `ofifo_empty` is 0 sets status bit 29. With `ofifo_empty` at 1 it sets nothing.
- R8: `ev_done` high while `ififo_empty` is 0 sets status bit 28. With `ififo_empty` at 1 it sets nothing.
- R9: `ififo_push` high while `ififo_full` is 1 sets status bit 26. A push with `ififo_full` at 0 sets nothing.
- R10: A write to 0x00 clears each status bit whose data bit is 1 and leaves the others. If a bit is cleared and newly detected in the same cycle, it stays set.
- R11: Status bits are sticky. `err_irq` and `core_halt` both equal the OR of the status register, and a later change to the mask does not alter bits already recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (8) | Byte offset within the unit's register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ev_done | input | 1 | Processing-done event pulse |
| ififo_push | input | 1 | Input FIFO push strobe |
| ififo_full | input | 1 | Input FIFO full flag |
| ififo_empty | input | 1 | Input FIFO empty flag |
| ofifo_empty | input | 1 | Output FIFO empty flag |
| err_irq | output | 1 | Error interrupt, OR of recorded status |
| core_halt | output | 1 | Halt request to the processing core |

## Verification
A wrong mask or status bit shows at the ports within one cycle. The next read of 0x00 or 0x04 returns a different word. For status, `err_irq` and `core_halt` also go wrong in the cycle after the triggering edge. The sweeps pair every error source with all 32 combinations of the defined mask bits. They also cover every offset of the 8-bit window and every mode value of a 4-bit field. A decode or masking fault therefore appears on the first status read after the affected trigger. Sticky-bit and clear faults show as irq or halt staying high or dropping early around status writes.

// File: rtl/err_guard_pkg.sv
package err_guard_pkg;
  localparam int REG_W   = 32;
  localparam int ERR_N   = 5;

  localparam int IDX_MODE = 0;
  localparam int IDX_ADDR = 1;
  localparam int IDX_OFE  = 2;
  localparam int IDX_IFE  = 3;
  localparam int IDX_OVF  = 4;

  localparam logic [7:0] OFS_STATUS = 8'h00;
  localparam logic [7:0] OFS_MASK   = 8'h04;
  localparam logic [7:0] OFS_MODE   = 8'h08;
  localparam logic [7:0] OFS_SIZE   = 8'h0C;

  function automatic int err_pos(input int idx);
    case (idx)
      IDX_MODE: err_pos = 31;
      IDX_ADDR: err_pos = 30;
      IDX_OFE:  err_pos = 29;
      IDX_IFE:  err_pos = 28;
      default:  err_pos = 26;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] err_spread(input logic [ERR_N-1:0] v);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i < ERR_N; i++) r[err_pos(i)] = v[i];
    return r;
  endfunction

  localparam logic [REG_W-1:0] ERR_DEFINED = 32'hF400_0000;
endpackage

// File: rtl/err_addr_decode.sv
module err_addr_decode
  import err_guard_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_MODES = 6
) (
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic              wr_status,
  output logic              wr_mask,
  output logic              wr_mode,
  output logic              wr_size,
  output logic              addr_bad,
  output logic              mode_bad
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_SIZE   = ADDR_W'(OFS_SIZE);

  logic hit_status, hit_mask, hit_mode, hit_size, hit_any, access;

  always_comb begin
    hit_status = (reg_addr == A_STATUS);
    hit_mask   = (reg_addr == A_MASK);
    hit_mode   = (reg_addr == A_MODE);
    hit_size   = (reg_addr == A_SIZE);
    hit_any    = hit_status | hit_mask | hit_mode | hit_size;
    access     = reg_wr | reg_rd;

    wr_status  = reg_wr & hit_status;
    wr_mask    = reg_wr & hit_mask;
    wr_mode    = reg_wr & hit_mode;
    wr_size    = reg_wr & hit_size;
    addr_bad   = access & ~hit_any;
    mode_bad   = wr_mode & (reg_wdata >= REG_W'(NUM_MODES));
  end
endmodule

// File: rtl/err_event_detect.sv
module err_event_detect
  import err_guard_pkg::*;
(
  input  logic             addr_bad,
  input  logic             mode_bad,
  input  logic             wr_size,
  input  logic             ev_done,
  input  logic             ififo_push,
  input  logic             ififo_full,
  input  logic             ififo_empty,
  input  logic             ofifo_empty,
  output logic [ERR_N-1:0] det
);
  always_comb begin
    det           = '0;
    det[IDX_MODE] = mode_bad;
    det[IDX_ADDR] = addr_bad;
    det[IDX_OFE]  = wr_size & ~ofifo_empty;
    det[IDX_IFE]  = ev_done & ~ififo_empty;
    det[IDX_OVF]  = ififo_push & ififo_full;
  end
endmodule

// File: rtl/err_status_bank.sv
module err_status_bank
  import err_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              wr_status,
  input  logic              wr_mask,
  input  logic              wr_mode,
  input  logic              mode_bad,
  input  logic [ERR_N-1:0]  det,
  output logic [REG_W-1:0]  status_q,
  output logic [REG_W-1:0]  mask_q,
  output logic [REG_W-1:0]  rdata
);
  logic [MODE_W-1:0] mode_q;
  logic [REG_W-1:0]  set_vec, clr_vec, status_d;

  // Only errors enabled by the mask in force before the edge are recorded.
  always_comb begin
    set_vec  = err_spread(det) & ~mask_q & ERR_DEFINED;
    clr_vec  = wr_status ? reg_wdata : '0;
    status_d = (status_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      mode_q   <= '0;
    end else begin
      status_q <= status_d;
      if (wr_mask) mask_q <= reg_wdata & ERR_DEFINED;
      if (wr_mode && !mode_bad) mode_q <= reg_wdata[MODE_W-1:0];
    end
  end

  always_comb begin
    if (reg_addr == ADDR_W'(OFS_STATUS))    rdata = status_q;
    else if (reg_addr == ADDR_W'(OFS_MASK)) rdata = mask_q;
    else if (reg_addr == ADDR_W'(OFS_MODE)) rdata = REG_W'(mode_q);
    else                                    rdata = '0;
  end
endmodule

// File: rtl/err_guard_unit.sv
module err_guard_unit
  import err_guard_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_MODES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ev_done,
  input  logic              ififo_push,
  input  logic              ififo_full,
  input  logic              ififo_empty,
  input  logic              ofifo_empty,
  output logic              err_irq,
  output logic              core_halt
);
  localparam int MODE_W = (NUM_MODES > 2) ? $clog2(NUM_MODES) : 1;

  logic             wr_status, wr_mask, wr_mode, wr_size, addr_bad, mode_bad;
  logic [ERR_N-1:0] det;
  logic [REG_W-1:0] status_q, mask_q;

  err_addr_decode #(.ADDR_W(ADDR_W), .NUM_MODES(NUM_MODES)) u_decode (
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .wr_status(wr_status), .wr_mask(wr_mask), .wr_mode(wr_mode), .wr_size(wr_size),
    .addr_bad(addr_bad), .mode_bad(mode_bad)
  );

  err_event_detect u_detect (
    .addr_bad(addr_bad), .mode_bad(mode_bad), .wr_size(wr_size),
    .ev_done(ev_done), .ififo_push(ififo_push), .ififo_full(ififo_full),
    .ififo_empty(ififo_empty), .ofifo_empty(ofifo_empty), .det(det)
  );

  err_status_bank #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .wr_status(wr_status), .wr_mask(wr_mask), .wr_mode(wr_mode),
    .mode_bad(mode_bad), .det(det),
    .status_q(status_q), .mask_q(mask_q), .rdata(reg_rdata)
  );

  assign err_irq   = |status_q;
  assign core_halt = |status_q;
endmodule

// File: rtl/err_guard_checker.sv
module err_guard_checker
  import err_guard_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             err_irq,
  input logic             core_halt,
  input logic             wr_status,
  input logic [31:0]      reg_wdata,
  input logic [ERR_N-1:0] det,
  input logic [31:0]      status_q,
  input logic [31:0]      mask_q
);
  // R4: an enabled detection raises the interrupt on the next cycle.
  a_r4_unmasked_raises: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_spread(det) & ~mask_q) != 0) |=> err_irq);

  // R3: with nothing recorded and only masked detections, nothing is recorded.
  a_r3_masked_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 0 && (err_spread(det) & ~mask_q) == 0) |=> (status_q == 0 && !err_irq));

  // R11: recorded errors persist unless software writes the status register.
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq && !wr_status) |=> err_irq);

  // R11: halt tracks the interrupt.
  a_r11_halt_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
    core_halt == err_irq);

  // R10: a full clear with no new detection empties the status register.
  a_r10_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && reg_wdata == 32'hFFFF_FFFF && det == 0) |=> (status_q == 0));

  // R2: only defined positions can ever be set in mask or status.
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & ~ERR_DEFINED) == 0) && ((status_q & ~ERR_DEFINED) == 0));
endmodule

bind err_guard_unit err_guard_checker u_checker (
  .clk(clk), .rst_n(rst_n), .err_irq(err_irq), .core_halt(core_halt),
  .wr_status(wr_status), .reg_wdata(reg_wdata), .det(det),
  .status_q(status_q), .mask_q(mask_q)
);

// File: tb/test_err_guard_unit.sv
module test_err_guard_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        ev_done = 0, ififo_push = 0, ififo_full = 0;
  logic        ififo_empty = 1, ofifo_empty = 1;
  logic        err_irq, core_halt;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_guard_unit i_err_guard_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_done(ev_done), .ififo_push(ififo_push), .ififo_full(ififo_full),
    .ififo_empty(ififo_empty), .ofifo_empty(ofifo_empty),
    .err_irq(err_irq), .core_halt(core_halt)
  );

  function automatic int pos_of(input int i);
    case (i) 0: return 31; 1: return 30; 2: return 29; 3: return 28; default: return 26; endcase
  endfunction

  function automatic logic [31:0] spread(input logic [4:0] m);
    logic [31:0] r = 0;
    for (int i = 0; i < 5; i++) r[pos_of(i)] = m[i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0; reg_addr = 0;
  endtask

  task automatic trigger(input int e);
    logic [31:0] dummy;
    case (e)
      0: bus_write(8'h08, 32'd9);
      1: bus_read(8'h10, dummy);
      2: begin ofifo_empty = 0; bus_write(8'h0C, 32'd16); ofifo_empty = 1; end
      3: begin ififo_empty = 0; ev_done = 1; @(negedge clk); ev_done = 0; ififo_empty = 1; end
      default: begin ififo_full = 1; ififo_push = 1; @(negedge clk); ififo_push = 0; ififo_full = 0; end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, exp_mode;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'd0, err_irq}, 0);
    check("R1 halt", {31'd0, core_halt}, 0);
    bus_read(8'h00, rd); check("R1 status", rd, 0);
    bus_read(8'h04, rd); check("R1 mask", rd, 0);
    bus_read(8'h08, rd); check("R1 mode", rd, 0);

    // R2 mask storage
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, rd); check("R2 mask defined bits", rd, 32'hF400_0000);
    bus_read(8'h0C, rd); check("R2 size reads zero", rd, 0);
    bus_write(8'h04, 0);

    // R3/R4/R7/R8/R9/R5/R6: each source against every mask combination
    for (int e = 0; e < 5; e++) begin
      for (int m = 0; m < 32; m++) begin
        logic [31:0] exp_s;
        bus_write(8'h04, spread(m[4:0]));
        bus_write(8'h00, 32'hFFFF_FFFF);
        trigger(e);
        exp_s = spread(~m[4:0] & (5'd1 << e));
        check(exp_s != 0 ? "R4 unmasked irq" : "R3 masked irq", {31'd0, err_irq}, {31'd0, exp_s != 0});
        check("R11 halt", {31'd0, core_halt}, {31'd0, exp_s != 0});
        bus_read(8'h00, rd);
        case (e)
          0: check("R5 mode err sweep", rd, exp_s);
          1: check("R6 addr err sweep", rd, exp_s);
          2: check("R7 ofifo err sweep", rd, exp_s);
          3: check("R8 ififo err sweep", rd, exp_s);
          default: check("R9 overflow sweep", rd, exp_s);
        endcase
      end
    end
    bus_write(8'h04, 0);
    bus_write(8'h00, 32'hFFFF_FFFF);

    // R7/R8/R9 negative cases: empty / not full sets nothing
    bus_write(8'h0C, 32'd4);
    ev_done = 1; @(negedge clk); ev_done = 0;
    ififo_push = 1; @(negedge clk); ififo_push = 0;
    bus_read(8'h00, rd); check("R7 R8 R9 benign events", rd, 0);

    // R6 full offset sweep
    for (int a = 0; a < 256; a++) begin
      bit legal;
      legal = (a == 0 || a == 4 || a == 8 || a == 12);
      if (a == 0) bus_write(8'h00, 0); else bus_read(a[7:0], rd);
      bus_read(8'h00, rd);
      check("R6 offset sweep", rd, legal ? 32'h0 : 32'h4000_0000);
      bus_write(8'h00, 32'hFFFF_FFFF);
    end

    // R5 mode value sweep
    exp_mode = 0;
    for (int v = 0; v < 16; v++) begin
      bus_write(8'h08, v);
      if (v < 6) exp_mode = v;
      bus_read(8'h08, rd); check("R5 mode readback", rd, exp_mode);
      bus_read(8'h00, rd); check("R5 mode status", rd, v >= 6 ? 32'h8000_0000 : 0);
      bus_write(8'h00, 32'hFFFF_FFFF);
    end

    // R10 partial clear
    trigger(1); trigger(3); trigger(4);
    bus_read(8'h00, rd); check("R10 three set", rd, 32'h5400_0000);
    bus_write(8'h00, 32'h1000_0000);
    bus_read(8'h00, rd); check("R10 partial clear", rd, 32'h4400_0000);
    check("R11 irq held", {31'd0, err_irq}, 1);

    // R10 set wins over clear in the same cycle
    ififo_full = 1; ififo_push = 1;
    bus_write(8'h00, 32'h0400_0000);
    ififo_full = 0; ififo_push = 0;
    bus_read(8'h00, rd); check("R10 set wins", rd, 32'h4400_0000);

    // R4 mask written in same cycle as error: old mask decides
    bus_write(8'h00, 32'hFFFF_FFFF);
    ififo_full = 1; ififo_push = 1;
    bus_write(8'h04, 32'hFFFF_FFFF);
    ififo_full = 0; ififo_push = 0;
    bus_read(8'h00, rd); check("R4 old mask decides", rd, 32'h0400_0000);

    // R11 later masking does not alter recorded bits
    bus_read(8'h00, rd); check("R11 recorded kept", rd, 32'h0400_0000);
    check("R11 irq with mask set", {31'd0, err_irq}, 1);
    bus_write(8'h00, 32'h0400_0000);
    check("R11 irq after clear", {31'd0, err_irq}, 0);
    check("R11 halt after clear", {31'd0, core_halt}, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule